// File: doc/BRIEF.md
# Page Translation and Select Decoder

This block sits between an 8-bit processor with a 16-bit logical address bus and a memory system of 256 KB. A small file of sixteen page entries, one per 4 KB logical page, widens every logical address to an 18-bit physical address. The top four logical address bits pick an entry. That entry's six bits become the upper physical bits, and the low twelve address bits pass straight through. Software loads the entries with ordinary CPU writes to the last sixteen bytes of the logical map. The entries cannot be read back.

The same translated page value also drives the chip selects. The low nibble of the page picks ROM, RAM or the I/O page on 4 KB boundaries. Inside the I/O page, the first 256 bytes are split into sixteen 16-byte device slots, the next 256 bytes go to a peripheral bus, and the rest is RAM. The top 256 bytes of the logical map skip translation entirely, so reads always reach ROM and writes always reach the page entries, whatever software has loaded. Translation and select decode are combinational and follow the address in the same cycle. Entry updates take effect at the next rising clock edge. There is no state machine; the only state is the entry file.

Top module: `dat_translator`

## Requirements
- R1: While reset (active high, synchronous) is asserted, entry n is loaded with value n. After reset, phys_addr equals the logical address zero-extended to 18 bits.
- R2: A cycle with cpu_vma=1, cpu_rw=0 and cpu_addr=$FFF0+n loads entry n with map_wdata. The new value appears on phys_addr from the next rising edge, and not before it.
- R3: phys_addr[17:12] equals the entry picked by cpu_addr[15:12], and phys_addr[11:0] equals cpu_addr[11:0].
- R4: For cpu_addr in $FF00–$FFFF with cpu_vma=1, a read (cpu_rw=1) asserts rom_sel and a write (cpu_rw=0) asserts map_sel, whatever the entries hold.
- R5: Entries do not change on writes to $FF00–$FFEF, on reads of $FFF0–$FFFF, or on any cycle with cpu_vma=0.
- R6: Outside $FFxx, a translated page whose low nibble is $F asserts rom_sel when cpu_addr[11]=1 and ram_sel when cpu_addr[11]=0.
- R7: Outside $FFxx, a translated page whose low nibble is $E asserts dev_sel when cpu_addr[11:8]=0, together with slot_sel bit cpu_addr[7:4] only. It asserts pbus_sel when cpu_addr[11:8]=1, and ram_sel for any other value of cpu_addr[11:8].
- R8: Any other low-nibble value asserts ram_sel. Translated page bits 5:4 do not affect the decode.
- R9: With cpu_vma=0 every select and every slot_sel bit is low. At most one of ram_sel, rom_sel, map_sel, dev_sel and pbus_sel is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_vma | input | 1 | Valid memory access qualifier |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 16 | Logical address |
| map_wdata | input | 6 | Low bits of the CPU write data, used for entry loads |
| phys_addr | output | 18 | Translated physical address |
| ram_sel | output | 1 | RAM select |
| rom_sel | output | 1 | ROM select |
| map_sel | output | 1 | Page-entry window select (fixed page write) |
| dev_sel | output | 1 | I/O device-slot area select |
| pbus_sel | output | 1 | Peripheral bus select |
| slot_sel | output | 16 | One-hot device slot, bit = cpu_addr[7:4] |

## Verification
Translation and every select are due in the same cycle as the address that causes them, so the bench drives inputs on the falling edge and samples 2 ns later, before the next rising edge. An entry load is due one rising edge after the write cycle. The bench checks phys_addr while the write is still presented, before the edge, to confirm the old value holds. It then checks again after the edge to confirm the new value. The sweep loads every 6-bit page value into the entries and probes offsets that land on each decode boundary.

// File: rtl/dat_pkg.sv
package dat_pkg;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_RAM,
        RGN_ROM,
        RGN_MAP,
        RGN_DEV,
        RGN_PBUS
    } region_e;

    // upper logical byte that bypasses translation
    localparam logic [7:0] FIXED_PAGE  = 8'hFF;
    // row of the fixed page that holds the entry window
    localparam logic [3:0] ENTRY_ROW   = 4'hF;
    // translated page nibbles with special decode
    localparam logic [3:0] NIB_ROMPAGE = 4'hF;
    localparam logic [3:0] NIB_IOPAGE  = 4'hE;
    // 256-byte sub-pages inside the I/O page
    localparam logic [3:0] SUB_DEV     = 4'h0;
    localparam logic [3:0] SUB_PBUS    = 4'h1;

endpackage

// File: rtl/dat_entry_file.sv
module dat_entry_file #(
    parameter int IDX_W  = 4,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PAGE_W-1:0] wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [PAGE_W-1:0] rd_page
);
    localparam int NUM_ENT = 2 ** IDX_W;

    logic [PAGE_W-1:0] ent_q [NUM_ENT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENT; i++) begin
                ent_q[i] <= PAGE_W'(i);
            end
        end else if (we) begin
            ent_q[wr_idx] <= wdata;
        end
    end

    assign rd_page = ent_q[rd_idx];

    // R2
    load_lands_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> ent_q[$past(wr_idx)] == $past(wdata));

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_hold
        // R5
        entry_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !(we && wr_idx == IDX_W'(g)) |=> $stable(ent_q[g]));
    end

endmodule

// File: rtl/dat_region_decode.sv
module dat_region_decode
    import dat_pkg::*;
#(
    parameter int LA_W = 16
) (
    input  logic            vma,
    input  logic            rw,
    input  logic [LA_W-1:0] addr,
    input  logic [3:0]      page_nib,
    output region_e         region
);
    localparam int OFS_W = LA_W - 4;

    logic       in_fixed;
    logic       rom_half;
    logic [3:0] sub_page;

    assign in_fixed = (addr[LA_W-1 -: 8] == FIXED_PAGE);
    assign rom_half = addr[OFS_W-1];
    assign sub_page = addr[OFS_W-1 -: 4];

    always_comb begin
        region = RGN_NONE;
        if (vma) begin
            if (in_fixed) begin
                region = rw ? RGN_ROM : RGN_MAP;
            end else begin
                unique case (page_nib)
                    NIB_ROMPAGE: region = rom_half ? RGN_ROM : RGN_RAM;
                    NIB_IOPAGE: begin
                        unique case (sub_page)
                            SUB_DEV:  region = RGN_DEV;
                            SUB_PBUS: region = RGN_PBUS;
                            default:  region = RGN_RAM;
                        endcase
                    end
                    default: region = RGN_RAM;
                endcase
            end
        end
    end

    // R4
    fixed_write_chk: assert final (!(vma && !rw && in_fixed) || region == RGN_MAP);

endmodule

// File: rtl/dat_slot_select.sv
module dat_slot_select #(
    parameter int SLOT_W = 4
) (
    input  logic                   en,
    input  logic [SLOT_W-1:0]      slot,
    output logic [2**SLOT_W-1:0]   slot_sel
);
    localparam int NUM_SLOTS = 2 ** SLOT_W;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign slot_sel[g] = en && (slot == SLOT_W'(g));
    end

endmodule

// File: rtl/dat_translator.sv
module dat_translator
    import dat_pkg::*;
#(
    parameter int LA_W   = 16,
    parameter int PA_W   = 18,
    parameter int IDX_W  = 4,
    parameter int SLOT_W = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cpu_vma,
    input  logic                      cpu_rw,
    input  logic [LA_W-1:0]           cpu_addr,
    input  logic [PA_W-LA_W+IDX_W-1:0] map_wdata,
    output logic [PA_W-1:0]           phys_addr,
    output logic                      ram_sel,
    output logic                      rom_sel,
    output logic                      map_sel,
    output logic                      dev_sel,
    output logic                      pbus_sel,
    output logic [2**SLOT_W-1:0]      slot_sel
);
    localparam int OFS_W  = LA_W - IDX_W;
    localparam int PAGE_W = PA_W - OFS_W;

    region_e           region;
    logic [PAGE_W-1:0] cur_page;
    logic              wr_en;

    dat_entry_file #(.IDX_W(IDX_W), .PAGE_W(PAGE_W)) entries_i (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .wr_idx  (cpu_addr[IDX_W-1:0]),
        .wdata   (map_wdata),
        .rd_idx  (cpu_addr[LA_W-1 -: IDX_W]),
        .rd_page (cur_page)
    );

    dat_region_decode #(.LA_W(LA_W)) decode_i (
        .vma      (cpu_vma),
        .rw       (cpu_rw),
        .addr     (cpu_addr),
        .page_nib (cur_page[3:0]),
        .region   (region)
    );

    dat_slot_select #(.SLOT_W(SLOT_W)) slots_i (
        .en       (dev_sel),
        .slot     (cpu_addr[4 +: SLOT_W]),
        .slot_sel (slot_sel)
    );

    assign wr_en     = (region == RGN_MAP) && (cpu_addr[4 +: 4] == ENTRY_ROW);
    assign phys_addr = {cur_page, cpu_addr[OFS_W-1:0]};

    always_comb begin
        ram_sel  = 1'b0;
        rom_sel  = 1'b0;
        map_sel  = 1'b0;
        dev_sel  = 1'b0;
        pbus_sel = 1'b0;
        unique case (region)
            RGN_RAM:  ram_sel  = 1'b1;
            RGN_ROM:  rom_sel  = 1'b1;
            RGN_MAP:  map_sel  = 1'b1;
            RGN_DEV:  dev_sel  = 1'b1;
            RGN_PBUS: pbus_sel = 1'b1;
            default:  ;
        endcase
    end

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_vma |-> !(ram_sel || rom_sel || map_sel || dev_sel || pbus_sel) && slot_sel == '0);

    // R4
    fixed_rom_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_vma && cpu_rw && cpu_addr[LA_W-1 -: 8] == FIXED_PAGE) |-> rom_sel);

    // R7
    slot_match_chk: assert property (@(posedge clk) disable iff (rst)
        dev_sel |-> slot_sel[cpu_addr[4 +: SLOT_W]] && $onehot(slot_sel));

    // R3
    page_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(cpu_addr[LA_W-1 -: IDX_W]) && !$past(wr_en))
            |-> $stable(phys_addr[PA_W-1 -: PAGE_W]));

endmodule

// File: tb/dat_translator_tb_top.sv
module dat_translator_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_vma;
    logic        cpu_rw;
    logic [15:0] cpu_addr;
    logic [5:0]  map_wdata;
    logic [17:0] phys_addr;
    logic        ram_sel, rom_sel, map_sel, dev_sel, pbus_sel;
    logic [15:0] slot_sel;

    int n_chk  = 0;
    int n_fail = 0;
    logic [5:0] model [16];

    always #4 clk = ~clk;

    dat_translator dut_i (
        .clk(clk), .rst(rst), .cpu_vma(cpu_vma), .cpu_rw(cpu_rw),
        .cpu_addr(cpu_addr), .map_wdata(map_wdata), .phys_addr(phys_addr),
        .ram_sel(ram_sel), .rom_sel(rom_sel), .map_sel(map_sel),
        .dev_sel(dev_sel), .pbus_sel(pbus_sel), .slot_sel(slot_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h addr=%h rw=%b vma=%b",
                     req, act, exp, cpu_addr, cpu_rw, cpu_vma);
        end
    endtask

    // {ram,rom,map,dev,pbus,slot[15:0]} from the requirements
    function automatic logic [20:0] exp_sel(input logic [5:0] pg, input logic [15:0] a,
                                            input logic rw, input logic vma);
        logic [4:0]  s = 5'b0;
        logic [15:0] sl = 16'h0;
        if (vma) begin
            if (a[15:8] == 8'hFF)             s = rw ? 5'b01000 : 5'b00100;
            else if (pg[3:0] == 4'hF)         s = a[11] ? 5'b01000 : 5'b10000;
            else if (pg[3:0] == 4'hE) begin
                if (a[11:8] == 4'h0) begin s = 5'b00010; sl = 16'h1 << a[7:4]; end
                else if (a[11:8] == 4'h1)     s = 5'b00001;
                else                          s = 5'b10000;
            end else                          s = 5'b10000;
        end
        return {s, sl};
    endfunction

    function automatic logic [20:0] got_sel();
        return {ram_sel, rom_sel, map_sel, dev_sel, pbus_sel, slot_sel};
    endfunction

    task automatic probe(input string req, input logic [15:0] a, input logic rw, input logic vma);
        @(negedge clk);
        cpu_addr = a; cpu_rw = rw; cpu_vma = vma;
        #2;
        chk({req, " phys"}, 32'(phys_addr), 32'({model[a[15:12]], a[11:0]}));
        chk({req, " sel"}, 32'(got_sel()), 32'(exp_sel(model[a[15:12]], a, rw, vma)));
    endtask

    task automatic load(input logic [3:0] n, input logic [5:0] v);
        @(negedge clk);
        cpu_addr = {12'hFFF, n}; cpu_rw = 1'b0; cpu_vma = 1'b1; map_wdata = v;
        #2;
        chk("R4 map_sel on entry write", 32'(got_sel()), 32'({5'b00100, 16'h0}));
        @(posedge clk);
        model[n] = v;
        @(negedge clk);
        cpu_vma = 1'b0; cpu_rw = 1'b1;
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [15:0] offs [9] = '{12'h000, 12'h0A7, 12'h0F5, 12'h100, 12'h1FF,
                                  12'h2C0, 12'h7FF, 12'h800, 12'hE55};
        for (int i = 0; i < 16; i++) model[i] = 6'(i);
        rst = 1'b1; cpu_vma = 1'b0; cpu_rw = 1'b1; cpu_addr = 16'h5432; map_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 reset phys identity", 32'(phys_addr), 32'h05432);
        chk("R9 reset no select", 32'(got_sel()), 32'h0);
        rst = 1'b0;

        // R1 / R6 / R8 identity map after reset
        for (int n = 0; n < 16; n++) begin
            probe("R1 identity", 16'(n << 12) | 16'h123, 1'b1, 1'b1);
            probe("R6 identity hi half", 16'(n << 12) | 16'h0A40, 1'b0, 1'b1);
        end

        // R2 timing: entry 15 update seen only after the edge
        @(negedge clk);
        cpu_addr = 16'hFFF5 & 16'hFFFF; cpu_addr = 16'hFFFF; cpu_rw = 1'b0; cpu_vma = 1'b1;
        map_wdata = 6'h2A;
        #2 chk("R2 old value before edge", 32'(phys_addr[17:12]), 32'h0F);
        @(negedge clk);
        cpu_vma = 1'b0; cpu_rw = 1'b1;
        #2 chk("R2 new value after edge", 32'(phys_addr[17:12]), 32'h2A);
        model[15] = 6'h2A;

        // R3 R6 R7 R8 sweep of every page value
        for (int v = 0; v < 64; v++) begin
            logic [3:0] k = 4'(v % 16);
            load(k, 6'(v));
            for (int j = 0; j < 9; j++) begin
                probe("R3/R6/R7/R8 sweep rd", {k, offs[j][11:0]}, 1'b1, 1'b1);
                probe("R3/R6/R7/R8 sweep wr", {k, offs[j][11:0]}, 1'b0, 1'b1);
            end
        end

        // R7 every device slot
        load(4'h3, 6'h1E);
        for (int s = 0; s < 16; s++) probe("R7 slot", 16'h3000 | 16'(s << 4) | 16'h9, 1'b1, 1'b1);

        // R4 fixed page with entry 15 remapped
        load(4'hF, 6'h05);
        probe("R4 fixed read FF00", 16'hFF00, 1'b1, 1'b1);
        probe("R4 fixed read FF80", 16'hFF80, 1'b1, 1'b1);
        probe("R4 fixed read FFFF", 16'hFFFF, 1'b1, 1'b1);
        probe("R4 fixed write FF10", 16'hFF10, 1'b0, 1'b1);

        // R5 stimuli that must not change entries
        load(4'h2, 6'h11);
        @(negedge clk); cpu_addr = 16'hFF32; cpu_rw = 1'b0; cpu_vma = 1'b1; map_wdata = 6'h3F;
        @(negedge clk); cpu_addr = 16'hFFF2; cpu_rw = 1'b0; cpu_vma = 1'b0; map_wdata = 6'h3C;
        @(negedge clk); cpu_addr = 16'hFFF2; cpu_rw = 1'b1; cpu_vma = 1'b1; map_wdata = 6'h3A;
        @(negedge clk); cpu_vma = 1'b0;
        probe("R5 entry2 unchanged", 16'h2345, 1'b1, 1'b1);
        probe("R5 entry15 unchanged", 16'hF001, 1'b1, 1'b1);

        // R9 idle: no selects with vma low
        for (int n = 0; n < 16; n++) probe("R9 vma low", 16'(n << 12) | 16'h0050, 1'b0, 1'b0);
        probe("R9 vma low fixed", 16'hFFF3, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule